// File: doc/BRIEF.md
# Timer Input Capture Channel

This block is one capture channel of a general-purpose timer. An asynchronous input pin is brought into the clock domain by a two-stage synchronizer. It then passes through a programmable noise filter and an edge detector, which fires on the rising or the falling edge. A prescaler lets through only every first, second, fourth or eighth qualifying edge. Each edge that passes takes a snapshot of the timer's free-running count, which arrives on an input port, and sets a capture flag.

The flag drives an interrupt request and a DMA request, and each request has its own enable. If another capture arrives while the flag is still set, an overcapture flag is set. Software clears both flags with a one-cycle clear strobe. The counter, the register decoding and the output-compare path all sit outside this block. Every control field is a plain input.

Top module: `capture_channel`

## Requirements
- R1: After reset, cap_flag, over_flag, irq_req and dma_req are 0 and cap_value is 0.
- R2: A capture loads cap_value with the count_val sampled at the capture edge and sets cap_flag. With filter code N and divider code 00, an active pin transition driven just after a clock edge produces a capture at the (N+4)th following rising clock edge, and not earlier.
- R3: With pol_sel = 0 only a rising pin edge is active. With pol_sel = 1 only a falling pin edge is active.
- R4: Filter code 0 passes the synchronized level straight through. A code N > 0 changes the filtered level only after N+1 consecutive samples at the new level, so a pulse of N cycles or fewer is discarded and a pulse of N+1 cycles is kept.
- R5: The divider code d (00, 01, 10, 11) makes a capture on every 2^d-th active edge, counted from the last prescaler reset.
- R6: A capture occurs only when ch_en = 1 and src_sel = 2'b01. Any other setting discards edges and leaves the flags and cap_value unchanged.
- R7: A capture while cap_flag is already 1 sets over_flag. over_flag is never 1 while cap_flag is 0.
- R8: A one-cycle flag_clr pulse clears cap_flag and over_flag. If a capture occurs in the same cycle, cap_flag ends at 1, over_flag at 0, and cap_value takes the new count.
- R9: irq_req equals cap_flag AND irq_en. dma_req equals cap_flag AND dma_en. Both are combinational.
- R10: The prescaler edge count returns to zero while ch_en = 0 and in any cycle where div_wr = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Asynchronous channel input pin |
| count_val | input | CNT_W | Free-running timer count |
| ch_en | input | 1 | Channel capture enable |
| src_sel | input | 2 | Channel source select; 2'b01 picks the direct pin |
| pol_sel | input | 1 | Active edge: 0 rising, 1 falling |
| filt_code | input | FLT_W | Filter sample-count code |
| div_code | input | DIV_W | Prescaler code: capture every 2^code edges |
| div_wr | input | 1 | Strobe marking a write of div_code |
| flag_clr | input | 1 | One-cycle clear of both flags |
| irq_en | input | 1 | Interrupt request enable |
| dma_en | input | 1 | DMA request enable |
| cap_value | output | CNT_W | Latched count at the last capture |
| cap_flag | output | 1 | Capture flag |
| over_flag | output | 1 | Overcapture flag |
| irq_req | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
Every filter code from 0 to 15 is swept under both polarities. For each one the bench checks that the flag is still clear one cycle before the computed capture edge and set on it. This shows that the cycle count through synchronizer, filter and edge register is right, and that the captured count matches that exact edge. Pulses of N and N+1 cycles at filter code 3 tell a working sample filter apart from one that is off by one. Runs of eight edges at each divider code tell the prescaler ratios apart. Further sequences cover gating by enable and source, a prescaler reset in the middle of a count, a second capture with no clear, a clear that lands on a capture edge, and all four request-enable combinations.

// File: rtl/capture_channel.sv
module capture_channel #(
  parameter int CNT_W = 16,
  parameter int FLT_W = 4,
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_in,
  input  logic [CNT_W-1:0] count_val,
  input  logic             ch_en,
  input  logic [1:0]       src_sel,
  input  logic             pol_sel,
  input  logic [FLT_W-1:0] filt_code,
  input  logic [DIV_W-1:0] div_code,
  input  logic             div_wr,
  input  logic             flag_clr,
  input  logic             irq_en,
  input  logic             dma_en,
  output logic [CNT_W-1:0] cap_value,
  output logic             cap_flag,
  output logic             over_flag,
  output logic             irq_req,
  output logic             dma_req
);

  localparam int EC_W = (1 << DIV_W) - 1;

  logic             sync_a, sync_b;
  logic [FLT_W-1:0] run_len;
  logic             filt_lvl, filt_prev;
  logic [EC_W-1:0]  edge_cnt;
  logic [EC_W-1:0]  edge_top;
  logic             rise, fall, active, armed, cap_evt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
    end else begin
      sync_a <= pin_in;
      sync_b <= sync_a;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      filt_lvl <= 1'b0;
      run_len  <= '0;
    end else if (sync_b == filt_lvl) begin
      run_len <= '0;
    end else if (run_len >= filt_code) begin
      filt_lvl <= sync_b;
      run_len  <= '0;
    end else begin
      run_len <= run_len + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) filt_prev <= 1'b0;
    else        filt_prev <= filt_lvl;

  assign rise   = filt_lvl & ~filt_prev;
  assign fall   = ~filt_lvl & filt_prev;
  assign active = pol_sel ? fall : rise;
  assign armed  = ch_en && (src_sel == 2'b01);

  assign edge_top = EC_W'((1 << div_code) - 1);
  assign cap_evt  = armed && active && (edge_cnt >= edge_top) && !div_wr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      edge_cnt <= '0;
    else if (!ch_en || div_wr)       edge_cnt <= '0;
    else if (armed && active)        edge_cnt <= (edge_cnt >= edge_top) ? '0 : edge_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cap_value <= '0;
      cap_flag  <= 1'b0;
      over_flag <= 1'b0;
    end else begin
      if (cap_evt) cap_value <= count_val;
      cap_flag  <= cap_evt | (cap_flag & ~flag_clr);
      over_flag <= flag_clr ? 1'b0 : (over_flag | (cap_evt & cap_flag));
    end

  assign irq_req = cap_flag & irq_en;
  assign dma_req = cap_flag & dma_en;

  assert_gated_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_flag) |-> $past(ch_en && src_sel == 2'b01));

  assert_value_with_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_value) |-> cap_flag);

  assert_over_implies_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    over_flag |-> cap_flag);

  assert_over_needs_prior_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(over_flag) |-> $past(cap_flag));

  assert_filter_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(filt_code) != '0 && filt_lvl != filt_prev) |-> ($past(sync_b, 1) == $past(sync_b, 2)));

  assert_psc_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!ch_en) || $past(div_wr)) |-> (edge_cnt == '0));

  assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> !over_flag);

endmodule

// File: tb/tb_capture_channel.sv
module tb_capture_channel;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pin_in = 1'b0;
  logic [CNT_W-1:0] count_val = '0;
  logic             ch_en = 1'b0;
  logic [1:0]       src_sel = 2'b01;
  logic             pol_sel = 1'b0;
  logic [3:0]       filt_code = '0;
  logic [1:0]       div_code = '0;
  logic             div_wr = 1'b0;
  logic             flag_clr = 1'b0;
  logic             irq_en = 1'b0;
  logic             dma_en = 1'b0;
  logic [CNT_W-1:0] cap_value;
  logic             cap_flag, over_flag, irq_req, dma_req;

  int checks = 0;
  int fails  = 0;

  capture_channel #(.CNT_W(CNT_W), .FLT_W(4), .DIV_W(2)) dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .count_val(count_val),
    .ch_en(ch_en), .src_sel(src_sel), .pol_sel(pol_sel), .filt_code(filt_code),
    .div_code(div_code), .div_wr(div_wr), .flag_clr(flag_clr),
    .irq_en(irq_en), .dma_en(dma_en), .cap_value(cap_value),
    .cap_flag(cap_flag), .over_flag(over_flag), .irq_req(irq_req), .dma_req(dma_req));

  always #2.5 clk = ~clk;

  initial forever begin
    @(posedge clk);
    count_val <= count_val + 1'b1;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_flags();
    flag_clr = 1'b1;
    tick(1);
    flag_clr = 1'b0;
  endtask

  task automatic pulse(input logic lvl_active, input int width, input int rest);
    pin_in = lvl_active;
    tick(width);
    pin_in = ~lvl_active;
    tick(rest);
  endtask

  initial begin
    tick(3);
    check("R1 cap_flag", cap_flag, 0);
    check("R1 over_flag", over_flag, 0);
    check("R1 cap_value", cap_value, 0);
    check("R1 requests", {irq_req, dma_req}, 0);
    rst_n = 1'b1;
    ch_en = 1'b1;
    tick(2);

    // R2 R3 R4: latency and snapshot across every filter code and both edges
    for (int p = 0; p < 2; p++) begin
      for (int n = 0; n < 16; n++) begin
        logic [CNT_W-1:0] c0;
        pol_sel   = p[0];
        filt_code = n[3:0];
        pin_in    = p[0];
        tick(24);
        clear_flags();
        c0 = count_val;
        pin_in = ~p[0];
        tick(3 + n);
        check($sformatf("R2 no early capture pol=%0d n=%0d", p, n), cap_flag, 0);
        tick(1);
        check($sformatf("R3 capture flag pol=%0d n=%0d", p, n), cap_flag, 1);
        check($sformatf("R2 captured count pol=%0d n=%0d", p, n), cap_value, 32'(CNT_W'(c0 + 3 + n)));
        pin_in = p[0];
        tick(24);
        check($sformatf("R3 inactive edge ignored pol=%0d n=%0d", p, n), over_flag, 0);
      end
    end

    // R4: glitch rejection at code 3
    pol_sel = 1'b0; filt_code = 4'd3; pin_in = 1'b0;
    tick(20); clear_flags();
    pulse(1'b1, 3, 20);
    check("R4 short pulse rejected", cap_flag, 0);
    pulse(1'b1, 4, 20);
    check("R4 pulse of N+1 kept", cap_flag, 1);

    // R5: prescaler ratios
    filt_code = 4'd0;
    for (int d = 0; d < 4; d++) begin
      div_code = d[1:0];
      div_wr = 1'b1; tick(1); div_wr = 1'b0;
      clear_flags();
      for (int k = 1; k <= 8; k++) begin
        pulse(1'b1, 3, 5);
        check($sformatf("R5 div=%0d edge %0d", d, k), cap_flag, ((k % (1 << d)) == 0) ? 1 : 0);
        if (cap_flag) clear_flags();
      end
    end

    // R6: gating
    div_code = 2'd0;
    ch_en = 1'b0;
    pulse(1'b1, 3, 6);
    check("R6 disabled no capture", cap_flag, 0);
    ch_en = 1'b1; src_sel = 2'b10;
    pulse(1'b1, 3, 6);
    check("R6 wrong source no capture", cap_flag, 0);
    check("R6 value held", {31'b0, cap_value == CNT_W'(0)}, 0);
    src_sel = 2'b01;

    // R10: prescaler reset by disable and by div_wr
    div_code = 2'd1;
    div_wr = 1'b1; tick(1); div_wr = 1'b0;
    pulse(1'b1, 3, 6);
    ch_en = 1'b0; tick(2); ch_en = 1'b1;
    pulse(1'b1, 3, 6);
    check("R10 disable restarts count", cap_flag, 0);
    pulse(1'b1, 3, 6);
    check("R10 second edge after restart", cap_flag, 1);
    clear_flags();
    div_code = 2'd3;
    div_wr = 1'b1; tick(1); div_wr = 1'b0;
    for (int k = 0; k < 3; k++) pulse(1'b1, 3, 5);
    div_wr = 1'b1; tick(1); div_wr = 1'b0;
    for (int k = 0; k < 7; k++) pulse(1'b1, 3, 5);
    check("R10 div_wr restarts count", cap_flag, 0);
    pulse(1'b1, 3, 5);
    check("R10 eighth edge after div_wr", cap_flag, 1);

    // R7 R8: overcapture and clear
    div_code = 2'd0;
    div_wr = 1'b1; tick(1); div_wr = 1'b0;
    clear_flags();
    pulse(1'b1, 3, 6);
    check("R7 single capture no over", over_flag, 0);
    pulse(1'b1, 3, 6);
    check("R7 second capture sets over", over_flag, 1);
    clear_flags();
    check("R8 clear cap_flag", cap_flag, 0);
    check("R8 clear over_flag", over_flag, 0);
    pulse(1'b1, 3, 6);
    begin
      logic [CNT_W-1:0] c1;
      c1 = count_val;
      pin_in = 1'b1;
      tick(3);
      flag_clr = 1'b1;
      tick(1);
      flag_clr = 1'b0;
      check("R8 clear with capture keeps flag", cap_flag, 1);
      check("R8 clear with capture no over", over_flag, 0);
      check("R8 clear with capture value", cap_value, 32'(CNT_W'(c1 + 3)));
      pin_in = 1'b0;
      tick(6);
    end

    // R9: request enables
    for (int e = 0; e < 4; e++) begin
      irq_en = e[0]; dma_en = e[1];
      tick(1);
      check($sformatf("R9 irq en=%0d", e), irq_req, e[0]);
      check($sformatf("R9 dma en=%0d", e), dma_req, e[1]);
    end
    clear_flags();
    check("R9 requests drop with flag", {irq_req, dma_req}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule